// File: doc/BRIEF.md
# Ethernet PHY Management Master with Continuous Polling

This block is the host side of a two-wire station-management link to external Ethernet PHYs. It generates the management clock (MDC) by dividing the host clock and runs the bidirectional data line (MDIO) through an output, an output-enable and an input pin. Complete clause-22 frames carry a single register read or write. Software controls the block through four small registers, all written over one narrow port. The registers set the target PHY and register, the data to write, the clock divide code and the command bits. One command bit asks for a single read. Another starts continuous polling: the addressed PHY register is re-read back to back, so a status bit such as link failure can be watched without software action. The most recent value read is always available on a read-data output, and a busy output shows when a frame is running or queued.

A frame has a preamble of 32 ones, the start pattern 01 and an opcode (10 for read, 01 for write). The PHY address and then the register address follow, five bits each and most significant bit first. Next comes a two-bit turnaround and then 16 data bits. The frame controller steps through the states IDLE, PREAMBLE, START, OPCODE, PHYADDR, REGADDR, TURN and DATA. IDLE goes to PREAMBLE when any request is pending. Each later state passes to the next one when the last bit of its field ends at a falling MDC edge. DATA returns to IDLE, and from IDLE the next frame can launch on the following cycle.

Top module: `mdio_master`

## Requirements
- R1: A write to the command register (select 0) with bit 0 set causes exactly one read frame: 32 ones, 01, opcode 10, PHY address, register address, then MDIO is released (mdio_oe low) for the turnaround and the 16 data bits. The bits sampled from mdio_i on the rising MDC edges of the data field, first bit as bit 15, appear on rd_data when the frame ends.
- R2: A write to the write-data register (select 2) starts one write frame: 32 ones, 01, opcode 01, PHY address, register address, turnaround 10 and the 16 written data bits, MSB first, with mdio_oe high throughout. rd_data is not changed by a write frame.
- R3: The address register (select 1) takes the register address from data bits 4:0 and the PHY address from bits 12:8. Command bit 1 is the polling bit.
- R4: The clock-select register (select 3) takes a 4-bit code in data bits 3:0. Codes 11, 12, 13, 14 and 15 give MDC periods of 48, 52, 56, 60 and 64 host cycles. Codes 0 to 10 give 48. MDC is low for the first half of each period and high for the second half.
- R5: While the polling bit is set, read frames follow one another and each one updates rd_data. When the bit is cleared, the frame in progress completes and no further frame starts.
- R6: busy is high while a frame runs or a request is pending. It falls only after the last data bit has completed.
- R7: Requests made during a frame are queued and served one after another. A queued write goes before a queued single read, and a single read goes before polling.
- R8: The PHY address, register address, write data and divide code are captured when a frame starts. Register writes during a frame affect only later frames.
- R9: After reset, rd_data is 0, busy is low, MDC is low and MDIO is released. Whenever busy is low, MDC stays low and MDIO stays released.
- R10: mdio_o and mdio_oe change only at a falling MDC edge, never while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 command, 1 address, 2 write data, 3 clock select |
| cfg_wdata | input | 16 | Register write data |
| rd_data | output | 16 | Last value returned by a read frame |
| busy | output | 1 | Frame running or request pending |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, low while released |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
A wrong state or bit counter in the frame controller shows at the ports within one frame. The serial bit string then has a misplaced field or the wrong length, or mdio_oe is released at the wrong bit. A PHY model that counts rising MDC edges catches this on the next completed frame. A bad capture shift register or a request flag left set shows once the frame ends: rd_data holds the wrong value, busy stays high, or extra frames appear while the line should be quiet. A wrong divide count shows in the measured MDC period of the very next frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int CODE_W  = 4;
    localparam int PRE_LEN = 32;
    localparam int BCNT_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_START,
        ST_OPCODE,
        ST_PHYADDR,
        ST_REGADDR,
        ST_TURN,
        ST_DATA
    } frm_state_t;

    typedef enum logic [1:0] {
        SEL_CMD   = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_WDATA = 2'd2,
        SEL_CLK   = 2'd3
    } cfg_sel_t;

    // Index of the first (most significant) bit sent in each field.
    function automatic logic [BCNT_W-1:0] field_top(input frm_state_t st);
        unique case (st)
            ST_PREAMBLE: return BCNT_W'(PRE_LEN - 1);
            ST_START:    return BCNT_W'(1);
            ST_OPCODE:   return BCNT_W'(1);
            ST_PHYADDR:  return BCNT_W'(ADDR_W - 1);
            ST_REGADDR:  return BCNT_W'(ADDR_W - 1);
            ST_TURN:     return BCNT_W'(1);
            ST_DATA:     return BCNT_W'(DATA_W - 1);
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/mdio_cfg_regs.sv
module mdio_cfg_regs
    import mdio_pkg::*;
#(
    parameter int DIV_BASE  = 48,
    parameter int DIV_STEP  = 4,
    parameter int CODE_BASE = 11,
    parameter int DIV_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              take_rd,
    input  logic              take_wr,
    output logic              rd_pend,
    output logic              wr_pend,
    output logic              scan_en,
    output logic [ADDR_W-1:0] phy_q,
    output logic [ADDR_W-1:0] reg_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DIV_W-1:0]  div_q
);

    localparam int PHY_LSB = 8;

    logic [1:0]        cmd_q;
    logic [CODE_W-1:0] code_q;
    cfg_sel_t          sel;

    assign sel = cfg_sel_t'(cfg_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            phy_q   <= '0;
            reg_q   <= '0;
            wdata_q <= '0;
            code_q  <= '0;
        end else if (cfg_we) begin
            unique case (sel)
                SEL_CMD:   cmd_q   <= cfg_wdata[1:0];
                SEL_ADDR: begin
                    reg_q <= cfg_wdata[ADDR_W-1:0];
                    phy_q <= cfg_wdata[PHY_LSB +: ADDR_W];
                end
                SEL_WDATA: wdata_q <= cfg_wdata;
                SEL_CLK:   code_q  <= cfg_wdata[CODE_W-1:0];
                default:   ;
            endcase
        end
    end

    // Pending request flags: a new request in the same cycle as a launch wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            if (cfg_we && sel == SEL_CMD && cfg_wdata[0])
                rd_pend <= 1'b1;
            else if (take_rd)
                rd_pend <= 1'b0;
            if (cfg_we && sel == SEL_WDATA)
                wr_pend <= 1'b1;
            else if (take_wr)
                wr_pend <= 1'b0;
        end
    end

    assign scan_en = cmd_q[1];

    always_comb begin
        if (code_q >= CODE_W'(CODE_BASE))
            div_q = DIV_W'(DIV_BASE + DIV_STEP * (int'(code_q) - CODE_BASE));
        else
            div_q = DIV_W'(DIV_BASE);
    end

endmodule

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             end_tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt_n;

    assign half      = div >> 1;
    assign cnt_n     = cnt + 1'b1;
    assign rise_tick = run && (cnt == half - 1'b1);
    assign end_tick  = run && (cnt == div - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (end_tick) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt_n;
            mdc <= (cnt_n >= half);
        end
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_pend,
    input  logic              wr_pend,
    input  logic              scan_en,
    input  logic [ADDR_W-1:0] phy_q,
    input  logic [ADDR_W-1:0] reg_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DIV_W-1:0]  div_q,
    input  logic              rise_tick,
    input  logic              end_tick,
    input  logic              mdio_i,
    output logic              take_rd,
    output logic              take_wr,
    output logic              frame_on,
    output logic [DIV_W-1:0]  div_act,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);

    frm_state_t        state, state_n;
    logic [BCNT_W-1:0] bcnt, bcnt_n;
    logic              go;
    logic              field_done;
    logic              is_wr;
    logic [ADDR_W-1:0] phy_l, reg_l;
    logic [DATA_W-1:0] wdata_l, cap;

    assign go         = rd_pend | wr_pend | scan_en;
    assign field_done = end_tick && (bcnt == '0);
    assign take_wr    = (state == ST_IDLE) && wr_pend;
    assign take_rd    = (state == ST_IDLE) && !wr_pend && rd_pend;
    assign frame_on   = (state != ST_IDLE);

    // Next state
    always_comb begin
        state_n = state;
        bcnt_n  = bcnt;
        unique case (state)
            ST_IDLE:     if (go) state_n = ST_PREAMBLE;
            ST_PREAMBLE: if (field_done) state_n = ST_START;
            ST_START:    if (field_done) state_n = ST_OPCODE;
            ST_OPCODE:   if (field_done) state_n = ST_PHYADDR;
            ST_PHYADDR:  if (field_done) state_n = ST_REGADDR;
            ST_REGADDR:  if (field_done) state_n = ST_TURN;
            ST_TURN:     if (field_done) state_n = ST_DATA;
            ST_DATA:     if (field_done) state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
        if (state_n != state)
            bcnt_n = field_top(state_n);
        else if (end_tick)
            bcnt_n = bcnt - 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            bcnt  <= '0;
        end else begin
            state <= state_n;
            bcnt  <= bcnt_n;
        end
    end

    // Frame parameters captured at launch, read capture and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_wr   <= 1'b0;
            phy_l   <= '0;
            reg_l   <= '0;
            wdata_l <= '0;
            div_act <= DIV_W'(2);
            cap     <= '0;
            rd_data <= '0;
        end else begin
            if (state == ST_IDLE && go) begin
                is_wr   <= wr_pend;
                phy_l   <= phy_q;
                reg_l   <= reg_q;
                wdata_l <= wdata_q;
                div_act <= div_q;
            end
            if (state == ST_DATA && !is_wr && rise_tick)
                cap <= {cap[DATA_W-2:0], mdio_i};
            if (state == ST_DATA && !is_wr && field_done)
                rd_data <= cap;
        end
    end

    // Line outputs
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b1;
        unique case (state)
            ST_IDLE:     mdio_oe = 1'b0;
            ST_PREAMBLE: mdio_o  = 1'b1;
            ST_START:    mdio_o  = (bcnt[0] == 1'b0);
            ST_OPCODE:   mdio_o  = is_wr ? (bcnt[0] == 1'b0) : (bcnt[0] == 1'b1);
            ST_PHYADDR:  mdio_o  = phy_l[bcnt[2:0]];
            ST_REGADDR:  mdio_o  = reg_l[bcnt[2:0]];
            ST_TURN: begin
                mdio_oe = is_wr;
                mdio_o  = is_wr && (bcnt[0] == 1'b1);
            end
            ST_DATA: begin
                mdio_oe = is_wr;
                mdio_o  = is_wr && wdata_l[bcnt[3:0]];
            end
            default:     mdio_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_BASE  = 48,
    parameter int DIV_STEP  = 4,
    parameter int CODE_BASE = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] rd_data,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    localparam int DIV_MAX = DIV_BASE + DIV_STEP * ((1 << CODE_W) - 1 - CODE_BASE);
    localparam int DIV_W   = $clog2(DIV_MAX + 1);

    logic              rd_pend, wr_pend, scan_en;
    logic              take_rd, take_wr, frame_on;
    logic              rise_tick, end_tick;
    logic [ADDR_W-1:0] phy_q, reg_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DIV_W-1:0]  div_q, div_act;

    mdio_cfg_regs #(
        .DIV_BASE (DIV_BASE),
        .DIV_STEP (DIV_STEP),
        .CODE_BASE(CODE_BASE),
        .DIV_W    (DIV_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .take_rd  (take_rd),
        .take_wr  (take_wr),
        .rd_pend  (rd_pend),
        .wr_pend  (wr_pend),
        .scan_en  (scan_en),
        .phy_q    (phy_q),
        .reg_q    (reg_q),
        .wdata_q  (wdata_q),
        .div_q    (div_q)
    );

    mdio_clkdiv #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (frame_on),
        .div      (div_act),
        .mdc      (mdc),
        .rise_tick(rise_tick),
        .end_tick (end_tick)
    );

    mdio_frame_fsm #(
        .DIV_W(DIV_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pend  (rd_pend),
        .wr_pend  (wr_pend),
        .scan_en  (scan_en),
        .phy_q    (phy_q),
        .reg_q    (reg_q),
        .wdata_q  (wdata_q),
        .div_q    (div_q),
        .rise_tick(rise_tick),
        .end_tick (end_tick),
        .mdio_i   (mdio_i),
        .take_rd  (take_rd),
        .take_wr  (take_wr),
        .frame_on (frame_on),
        .div_act  (div_act),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_data  (rd_data)
    );

    assign busy = frame_on | rd_pend | wr_pend | scan_en;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int MIN_HALF = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [15:0] rd_data
);

    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (mdc)
            hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1;
        else
            hi_cnt <= '0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R9

    AST_LINE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R10

    AST_RESULT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $fell(mdc)); // R1

    AST_MDC_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy); // R6

    AST_BUSY_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !mdc); // R6

    AST_MDC_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_cnt >= 8'(MIN_HALF))); // R4

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .rd_data(rd_data)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] rd_data;
    logic        busy, mdc, mdio_o, mdio_oe, mdio_i;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mdio_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_data(rd_data), .busy(busy), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: counts rising MDC edges, records the frame, answers reads
    int          pos_cnt = 0;
    int          frames = 0;
    int          last_rise = 0;
    int          period = 0;
    logic [63:0] cur_bits = '0, cur_oe = '0, last_bits = '0, last_oe = '0;
    logic [15:0] resp = 16'h0000;

    assign mdio_i = (pos_cnt >= 48) ? resp[63 - pos_cnt] : 1'b1;

    always @(posedge clk) cyc = cyc + 1;

    always @(posedge mdc) begin
        if (pos_cnt == 10) period = cyc - last_rise;
        last_rise = cyc;
        cur_bits[63 - pos_cnt] = mdio_o;
        cur_oe[63 - pos_cnt]   = mdio_oe;
        if (pos_cnt == 63) begin
            last_bits = cur_bits;
            last_oe   = cur_oe;
            frames    = frames + 1;
            pos_cnt   = 0;
        end else begin
            pos_cnt = pos_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] addr_word(input logic [4:0] phy, input logic [4:0] rg);
        return {3'b000, phy, 3'b000, rg};
    endfunction

    function automatic logic [63:0] exp_bits(input bit wr, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
                (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0000)};
    endfunction

    function automatic logic [63:0] exp_oe(input bit wr);
        return wr ? {64{1'b1}} : {{46{1'b1}}, 18'b0};
    endfunction

    task automatic wait_frames(input int target);
        while (frames < target) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic wait_pos(input int n);
        while (pos_cnt != n) @(negedge clk);
    endtask

    task automatic check_frame(input string req, input bit wr, input logic [4:0] phy,
                               input logic [4:0] rg, input logic [15:0] d);
        logic [63:0] m;
        m = exp_oe(wr);
        check((last_bits & m) == (exp_bits(wr, phy, rg, d) & m), req, last_bits, exp_bits(wr, phy, rg, d));
        check(last_oe == m, req, last_oe, m);
    endtask

    task automatic t_reset();
        check(rd_data == 16'h0 && !busy && !mdc && !mdio_oe, "R9 reset state",
              {rd_data, busy, mdc, mdio_oe}, 64'h0);
    endtask

    task automatic t_single_read();
        int f;
        f = frames;
        resp = 16'hA5C3;
        cfg_write(2'd1, addr_word(5'h11, 5'h02));
        cfg_write(2'd0, 16'h0001);
        wait_pos(5);
        @(negedge clk);
        check(busy == 1'b1, "R6 busy in frame", busy, 1);
        wait_frames(f + 1);
        wait_idle();
        check_frame("R1 R3 read frame", 1'b0, 5'h11, 5'h02, 16'h0);
        check(rd_data == 16'hA5C3, "R1 read result", rd_data, 16'hA5C3);
        check(busy == 1'b0, "R6 busy low after frame", busy, 0);
        cfg_write(2'd0, 16'h0000);
        repeat (4000) @(negedge clk);
        check(frames == f + 1, "R1 exactly one frame", frames, f + 1);
    endtask

    task automatic t_write();
        int f;
        f = frames;
        cfg_write(2'd1, addr_word(5'h03, 5'h1E));
        cfg_write(2'd2, 16'h3C5A);
        wait_frames(f + 1);
        wait_idle();
        check_frame("R2 write frame", 1'b1, 5'h03, 5'h1E, 16'h3C5A);
        check(rd_data == 16'hA5C3, "R2 rd_data kept", rd_data, 16'hA5C3);
    endtask

    task automatic t_divider();
        logic [3:0] codes [5] = '{4'd0, 4'd11, 4'd12, 4'd14, 4'd15};
        int         divs  [5] = '{48, 48, 52, 60, 64};
        for (int i = 0; i < 5; i++) begin
            int f;
            f = frames;
            cfg_write(2'd3, {12'h0, codes[i]});
            cfg_write(2'd2, 16'h0F0F);
            wait_frames(f + 1);
            wait_idle();
            check(period == divs[i], "R4 MDC period", period, divs[i]);
        end
        cfg_write(2'd3, 16'h000B);
    endtask

    task automatic t_scan();
        int f;
        f = frames;
        resp = 16'h1111;
        cfg_write(2'd1, addr_word(5'h01, 5'h01));
        cfg_write(2'd0, 16'h0002);
        wait_frames(f + 1);
        repeat (40) @(negedge clk);
        check(rd_data == 16'h1111, "R5 poll update 1", rd_data, 16'h1111);
        check(busy == 1'b1, "R6 busy while polling", busy, 1);
        resp = 16'h2222;
        wait_frames(f + 2);
        repeat (40) @(negedge clk);
        check(rd_data == 16'h2222, "R5 poll update 2", rd_data, 16'h2222);
        check_frame("R5 poll frame", 1'b0, 5'h01, 5'h01, 16'h0);
        resp = 16'h3333;
        wait_pos(20);
        cfg_write(2'd0, 16'h0000);
        wait_idle();
        check(frames == f + 3, "R5 frame finishes after stop", frames, f + 3);
        check(rd_data == 16'h3333, "R5 last poll result", rd_data, 16'h3333);
        repeat (5000) @(negedge clk);
        check(frames == f + 3, "R5 no frame after stop", frames, f + 3);
    endtask

    task automatic t_queued();
        int f;
        f = frames;
        resp = 16'hBEEF;
        cfg_write(2'd1, addr_word(5'h07, 5'h04));
        cfg_write(2'd0, 16'h0001);
        wait_pos(10);
        cfg_write(2'd1, addr_word(5'h1A, 5'h13));
        cfg_write(2'd0, 16'h0001);
        cfg_write(2'd2, 16'h8001);
        wait_frames(f + 1);
        check_frame("R8 launch-time address", 1'b0, 5'h07, 5'h04, 16'h0);
        wait_frames(f + 2);
        check_frame("R7 queued write first", 1'b1, 5'h1A, 5'h13, 16'h8001);
        resp = 16'hC0DE;
        wait_frames(f + 3);
        wait_idle();
        check_frame("R7 queued read second", 1'b0, 5'h1A, 5'h13, 16'h0);
        check(rd_data == 16'hC0DE, "R7 queued read result", rd_data, 16'hC0DE);
        check(frames == f + 3, "R7 no extra frame", frames, f + 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_read();
        t_write();
        t_divider();
        t_scan();
        t_queued();
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 190000) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule